// File: doc/BRIEF.md
# Read-Modify-Write Execution Unit

This unit performs the data half of the read-modify-write and store instructions of an 8-bit accumulator processor. The unit receives a memory operand that has already been fetched, together with the accumulator, the X and Y registers, the current status flags and a 4-bit operation code. It returns the byte to write back to memory, an optional new accumulator value and the updated carry, zero, negative and overflow flags. Address generation, decode and bus timing stay with the surrounding core.

Besides increment, a logical right shift and left and right rotates through carry, the unit handles two plain stores: Y, and A AND X. It also has four fused operations. Each one shifts or rotates the memory byte, writes that byte back, and then merges it into the accumulator with AND, OR, XOR or a binary add-with-carry. When the accumulator-mode input is set, the plain shift and rotate operations send their result to the accumulator and do not write memory.

A small two-state sequencer runs the unit. In IDLE, the outputs are held and the strobes are low. A start pulse takes it to DONE, where the registered result is presented with `done` high for one cycle. DONE goes back to IDLE if no start arrives, or stays in DONE if a new start arrives in that cycle.

Top module: `rmw_exec_unit`

## Requirements
- R1: After reset, `done`, `wr_en` and `a_wr` are low.
- R2: A result captured on a start edge appears on the following cycle with `done` high. `done` is high only in the cycle after a start, and back-to-back starts are accepted.
- R3: Op 0 (increment) writes (operand+1) mod 256 to memory and sets Z and N from that byte. C and V keep their incoming values.
- R4: Op 1 (shift right) moves operand bit 0 into C, fills bit 7 with zero, sets Z when the result is zero and always clears N. V is kept.
- R5: Op 2 (rotate left) moves the incoming C into bit 0 and bit 7 into C. Op 3 (rotate right) moves the incoming C into bit 7 and bit 0 into C. For both, Z and N come from the rotated byte and V is kept.
- R6: For ops 1, 2 and 3 with `acc_mode` high, the result goes to `a_out` with `a_wr` high and `wr_en` low. Every other op ignores `acc_mode`.
- R7: Op 6 shifts the operand left with a zero fill, moves bit 7 into C, writes the shifted byte and ORs it into the accumulator. Z and N come from the new accumulator.
- R8: Op 7 rotates the operand left through C, writes the rotated byte and ANDs it into the accumulator. Z and N come from the new accumulator, and C is the bit rotated out.
- R9: Op 8 shifts the operand right with a zero fill, moves bit 0 into C, writes the byte and XORs it into the accumulator. Z and N come from the new accumulator.
- R10: Op 9 rotates the operand right through C, writes the byte and adds it to A in binary, using the rotated-out bit as carry-in. C is bit 8 of the sum. V is set when both addends have equal sign bits that differ from the sign bit of the sum. Z and N come from the 8-bit sum.
- R11: Op 4 writes Y and op 5 writes A AND X to memory. Neither changes any flag.
- R12: Op codes 10 to 15 write neither memory nor the accumulator and leave all flags at their incoming values. When `a_wr` is low, `a_out` equals the captured A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture the inputs and execute |
| op | input | 4 | Operation code |
| acc_mode | input | 1 | Target accumulator for shift/rotate ops |
| operand | input | 8 | Fetched memory byte |
| a_in | input | 8 | Accumulator |
| x_in | input | 8 | X register |
| y_in | input | 8 | Y register |
| c_in | input | 1 | Incoming carry |
| z_in | input | 1 | Incoming zero flag |
| n_in | input | 1 | Incoming negative flag |
| v_in | input | 1 | Incoming overflow flag |
| done | output | 1 | Result valid strobe |
| wr_en | output | 1 | Memory write enable (with done) |
| wr_data | output | 8 | Memory write-back byte |
| a_wr | output | 1 | Accumulator write enable (with done) |
| a_out | output | 8 | New accumulator value |
| c_out | output | 1 | Carry result |
| z_out | output | 1 | Zero result |
| n_out | output | 1 | Negative result |
| v_out | output | 1 | Overflow result |

## Verification
In the fused operations, the memory write-back and the accumulator merge both happen in the same DONE cycle. The merge depends on the carry from the rotate, so a fault in the shared carry can corrupt either result. Every operation runs against every operand value with both carry inputs, and the accumulator varies with the operand. Each DONE cycle is judged by comparing `wr_data`, `a_out`, both strobes and all four flags together against arithmetic computed in the bench. The starts are issued back to back, so a new start in DONE also tests that the sequencer stays in DONE.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
    localparam int DATA_W = 8;
    localparam int OP_W   = 4;

    localparam logic [OP_W-1:0] OP_INC     = 4'd0;
    localparam logic [OP_W-1:0] OP_SHR     = 4'd1;
    localparam logic [OP_W-1:0] OP_ROL     = 4'd2;
    localparam logic [OP_W-1:0] OP_ROR     = 4'd3;
    localparam logic [OP_W-1:0] OP_STY     = 4'd4;
    localparam logic [OP_W-1:0] OP_STAX    = 4'd5;
    localparam logic [OP_W-1:0] OP_SHL_OR  = 4'd6;
    localparam logic [OP_W-1:0] OP_ROL_AND = 4'd7;
    localparam logic [OP_W-1:0] OP_SHR_XOR = 4'd8;
    localparam logic [OP_W-1:0] OP_ROR_ADD = 4'd9;

    typedef enum logic {ST_IDLE = 1'b0, ST_DONE = 1'b1} seq_state_e;

    typedef struct packed {
        logic              mem_we;
        logic [DATA_W-1:0] mem_data;
        logic              acc_we;
        logic [DATA_W-1:0] acc;
        logic              c;
        logic              z;
        logic              n;
        logic              v;
    } rmw_res_t;
endpackage

// File: rtl/rmw_shift_core.sv
module rmw_shift_core
    import rmw_pkg::*;
(
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] x_in,
    input  logic [DATA_W-1:0] y_in,
    input  logic              c_in,
    output logic [DATA_W-1:0] mod_byte,
    output logic              out_carry
);
    localparam int MSB = DATA_W - 1;

    always_comb begin
        mod_byte  = operand;
        out_carry = c_in;
        unique case (op)
            OP_INC: mod_byte = operand + 1'b1;
            OP_SHR, OP_SHR_XOR: begin
                mod_byte  = {1'b0, operand[MSB:1]};
                out_carry = operand[0];
            end
            OP_ROL, OP_ROL_AND: begin
                mod_byte  = {operand[MSB-1:0], c_in};
                out_carry = operand[MSB];
            end
            OP_SHL_OR: begin
                mod_byte  = {operand[MSB-1:0], 1'b0};
                out_carry = operand[MSB];
            end
            OP_ROR, OP_ROR_ADD: begin
                mod_byte  = {c_in, operand[MSB:1]};
                out_carry = operand[0];
            end
            OP_STY:  mod_byte = y_in;
            OP_STAX: mod_byte = a_in & x_in;
            default: mod_byte = operand;
        endcase
    end
endmodule

// File: rtl/rmw_acc_merge.sv
module rmw_acc_merge
    import rmw_pkg::*;
(
    input  logic [OP_W-1:0]   op,
    input  logic              acc_mode,
    input  logic [DATA_W-1:0] mod_byte,
    input  logic              shift_carry,
    input  logic [DATA_W-1:0] a_in,
    input  logic              c_in,
    input  logic              z_in,
    input  logic              n_in,
    input  logic              v_in,
    output rmw_res_t          res
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0]   sum;
    logic [DATA_W-1:0] merged;

    assign sum = {1'b0, a_in} + {1'b0, mod_byte} + {{DATA_W{1'b0}}, shift_carry};

    always_comb begin
        unique case (op)
            OP_SHL_OR:  merged = a_in | mod_byte;
            OP_ROL_AND: merged = a_in & mod_byte;
            OP_SHR_XOR: merged = a_in ^ mod_byte;
            OP_ROR_ADD: merged = sum[MSB:0];
            default:    merged = a_in;
        endcase
    end

    always_comb begin
        res.mem_we   = 1'b0;
        res.mem_data = mod_byte;
        res.acc_we   = 1'b0;
        res.acc      = a_in;
        res.c        = c_in;
        res.z        = z_in;
        res.n        = n_in;
        res.v        = v_in;
        unique case (op)
            OP_INC: begin
                res.mem_we = 1'b1;
                res.z      = (mod_byte == '0);
                res.n      = mod_byte[MSB];
            end
            OP_SHR, OP_ROL, OP_ROR: begin
                res.c = shift_carry;
                res.z = (mod_byte == '0);
                res.n = (op == OP_SHR) ? 1'b0 : mod_byte[MSB];
                if (acc_mode) begin
                    res.acc_we = 1'b1;
                    res.acc    = mod_byte;
                end else begin
                    res.mem_we = 1'b1;
                end
            end
            OP_STY, OP_STAX: res.mem_we = 1'b1;
            OP_SHL_OR, OP_ROL_AND, OP_SHR_XOR, OP_ROR_ADD: begin
                res.mem_we = 1'b1;
                res.acc_we = 1'b1;
                res.acc    = merged;
                res.z      = (merged == '0);
                res.n      = merged[MSB];
                if (op == OP_ROR_ADD) begin
                    res.c = sum[DATA_W];
                    res.v = (a_in[MSB] == mod_byte[MSB]) && (sum[MSB] != a_in[MSB]);
                end else begin
                    res.c = shift_carry;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rmw_seq_ctrl.sv
module rmw_seq_ctrl
    import rmw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic capture,
    output logic done
);
    seq_state_e state_q, state_d;

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = start ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = start ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        capture = start;
        done    = (state_q == ST_DONE);
    end
endmodule

// File: rtl/rmw_exec_unit.sv
module rmw_exec_unit
    import rmw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OP_W-1:0]   op,
    input  logic              acc_mode,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] x_in,
    input  logic [DATA_W-1:0] y_in,
    input  logic              c_in,
    input  logic              z_in,
    input  logic              n_in,
    input  logic              v_in,
    output logic              done,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              a_wr,
    output logic [DATA_W-1:0] a_out,
    output logic              c_out,
    output logic              z_out,
    output logic              n_out,
    output logic              v_out
);
    logic [DATA_W-1:0] mod_byte;
    logic              shift_carry;
    logic              capture;
    rmw_res_t          res_d, res_q;

    rmw_shift_core u_shift (
        .op(op), .operand(operand), .a_in(a_in), .x_in(x_in), .y_in(y_in),
        .c_in(c_in), .mod_byte(mod_byte), .out_carry(shift_carry)
    );

    rmw_acc_merge u_merge (
        .op(op), .acc_mode(acc_mode), .mod_byte(mod_byte), .shift_carry(shift_carry),
        .a_in(a_in), .c_in(c_in), .z_in(z_in), .n_in(n_in), .v_in(v_in), .res(res_d)
    );

    rmw_seq_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .capture(capture), .done(done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       res_q <= '0;
        else if (capture) res_q <= res_d;
    end

    always_comb begin
        wr_en   = done & res_q.mem_we;
        wr_data = res_q.mem_data;
        a_wr    = done & res_q.acc_we;
        a_out   = res_q.acc;
        c_out   = res_q.c;
        z_out   = res_q.z;
        n_out   = res_q.n;
        v_out   = res_q.v;
    end
endmodule

// File: rtl/rmw_exec_unit_chk.sv
module rmw_exec_unit_chk
    import rmw_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [OP_W-1:0]   op,
    input logic              acc_mode,
    input logic              c_in,
    input logic              z_in,
    input logic              n_in,
    input logic              v_in,
    input logic              done,
    input logic              wr_en,
    input logic              a_wr,
    input logic              c_out,
    input logic              z_out,
    input logic              n_out,
    input logic              v_out
);
    a_r2_done_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    a_r2_done_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start));

    a_r3_inc_keeps_cv: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == OP_INC) |=> (c_out == $past(c_in) && v_out == $past(v_in) && wr_en));

    a_r6_acc_target: assert property (@(posedge clk) disable iff (!rst_n)
        (start && acc_mode && (op == OP_SHR || op == OP_ROL || op == OP_ROR)) |=> (a_wr && !wr_en));

    a_r11_store_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (op == OP_STY || op == OP_STAX)) |=>
        (c_out == $past(c_in) && z_out == $past(z_in) && n_out == $past(n_in)
         && v_out == $past(v_in) && wr_en && !a_wr));

    a_r12_unused_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op > OP_ROR_ADD) |=> (!wr_en && !a_wr));
endmodule

bind rmw_exec_unit rmw_exec_unit_chk u_chk (.*);

// File: tb/test_rmw_exec_unit.sv
module test_rmw_exec_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] op = '0;
    logic       acc_mode = 1'b0;
    logic [7:0] operand = '0, a_in = '0, x_in = '0, y_in = '0;
    logic       c_in = 1'b0, z_in = 1'b0, n_in = 1'b0, v_in = 1'b0;
    logic       done, wr_en, a_wr, c_out, z_out, n_out, v_out;
    logic [7:0] wr_data, a_out;

    int vectors = 0;
    int errors  = 0;

    always #10 clk = ~clk;

    rmw_exec_unit i_rmw_exec_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .acc_mode(acc_mode),
        .operand(operand), .a_in(a_in), .x_in(x_in), .y_in(y_in),
        .c_in(c_in), .z_in(z_in), .n_in(n_in), .v_in(v_in),
        .done(done), .wr_en(wr_en), .wr_data(wr_data), .a_wr(a_wr), .a_out(a_out),
        .c_out(c_out), .z_out(z_out), .n_out(n_out), .v_out(v_out)
    );

    function automatic string req_of(input int o, input bit am);
        case (o)
            0: return "R3";
            1: return am ? "R6" : "R4";
            2, 3: return am ? "R6" : "R5";
            4, 5: return "R11";
            6: return "R7";
            7: return "R8";
            8: return "R9";
            9: return "R10";
            default: return "R12";
        endcase
    endfunction

    task automatic check_vec(input int o, input bit am);
        int m, cc, acc, e_wd, e_a, s;
        bit e_we, e_aw, e_c, e_z, e_n, e_v;
        m = operand; cc = c_in; acc = a_in;
        e_we = 0; e_aw = 0; e_wd = 0; e_a = acc;
        e_c = c_in; e_z = z_in; e_n = n_in; e_v = v_in;
        case (o)
            0: begin e_we = 1; e_wd = (m + 1) % 256; e_z = (e_wd == 0); e_n = e_wd >= 128; end
            1, 2, 3: begin
                if (o == 1) begin e_wd = m / 2; e_c = m % 2; end
                else if (o == 2) begin e_wd = (m * 2 + cc) % 256; e_c = m >= 128; end
                else begin e_wd = cc * 128 + m / 2; e_c = m % 2; end
                e_z = (e_wd == 0); e_n = (o == 1) ? 1'b0 : (e_wd >= 128);
                if (am) begin e_aw = 1; e_a = e_wd; end else e_we = 1;
            end
            4: begin e_we = 1; e_wd = y_in; end
            5: begin e_we = 1; e_wd = a_in & x_in; end
            6, 7, 8, 9: begin
                e_we = 1; e_aw = 1;
                if (o == 6) begin e_wd = (m * 2) % 256; e_c = m >= 128; e_a = acc | e_wd; end
                else if (o == 7) begin e_wd = (m * 2 + cc) % 256; e_c = m >= 128; e_a = acc & e_wd; end
                else if (o == 8) begin e_wd = m / 2; e_c = m % 2; e_a = acc ^ e_wd; end
                else begin
                    e_wd = cc * 128 + m / 2;
                    s = acc + e_wd + (m % 2);
                    e_a = s % 256; e_c = s >= 256;
                    e_v = ((acc >= 128) == (e_wd >= 128)) && ((e_a >= 128) != (acc >= 128));
                end
                e_z = (e_a == 0); e_n = e_a >= 128;
            end
            default: ;
        endcase
        vectors++;
        if (!done || wr_en !== e_we || a_wr !== e_aw || a_out !== 8'(e_a)
            || (e_we && wr_data !== 8'(e_wd))
            || c_out !== e_c || z_out !== e_z || n_out !== e_n || v_out !== e_v) begin
            errors++;
            $display("FAIL %s op=%0d am=%0d m=%02h c=%0d: got done=%0b we=%0b wd=%02h aw=%0b a=%02h cznv=%0b%0b%0b%0b exp we=%0b wd=%02h aw=%0b a=%02h cznv=%0b%0b%0b%0b",
                     req_of(o, am), o, am, m, cc, done, wr_en, wr_data, a_wr, a_out,
                     c_out, z_out, n_out, v_out, e_we, 8'(e_wd), e_aw, 8'(e_a), e_c, e_z, e_n, e_v);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout, exp completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        vectors++;
        if (done !== 1'b0 || wr_en !== 1'b0 || a_wr !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: got done=%0b we=%0b aw=%0b exp 0 0 0", done, wr_en, a_wr);
        end
        rst_n = 1'b1;
        @(negedge clk);
        for (int o = 0; o < 16; o++) begin
            for (int am = 0; am < 2; am++) begin
                for (int v = 0; v < 512; v++) begin
                    op = 4'(o); acc_mode = am[0];
                    operand = v[7:0]; c_in = v[8];
                    a_in = 8'(v * 37 + o * 11);
                    x_in = v[7:0] ^ 8'hA5;
                    y_in = 8'(v * 5 + 3);
                    z_in = v[2]; n_in = v[5] ^ v[8]; v_in = v[6];
                    start = 1'b1;
                    @(negedge clk);
                    start = 1'b0;
                    check_vec(o, am[0]);
                end
                @(negedge clk);
                vectors++;
                if (done !== 1'b0 || wr_en !== 1'b0 || a_wr !== 1'b0) begin
                    errors++;
                    $display("FAIL R2 idle after last start: got done=%0b we=%0b aw=%0b exp 0 0 0",
                             done, wr_en, a_wr);
                end
            end
        end
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule